// File: doc/BRIEF.md
# Standalone Level-1 Trigger Emulator

This block produces level-1 accept pulses on a bunch-crossing clock for a detector that runs without its central trigger system. The same timing constraints apply as in a full-system run. The accept candidates come from a 32-bit pseudo-random source compared against a programmable threshold. With a 40 MHz clock, a threshold near 2^32/400 gives a mean rate of about 100 kHz.

Each candidate must pass four gates before it becomes an accept:
- a veto window placed around every orbit boundary;
- a fixed simple deadtime that follows each accept;
- a leaky-bucket deadtime that limits bursts;
- an external busy input.

The block also keeps a bunch-crossing counter that wraps once per orbit, with an orbit pulse at each wrap. It keeps an event counter that counts accepts. Software may clear the event counter, and the clear is applied only at the next orbit boundary. Every accept carries an 8-bit trigger-type word.

Software sets all parameters through a simple write-only register port. A register write takes effect for the accept decision made at the following clock edge. All outputs come from registers. An accept decided at clock edge e is high in the cycle after e. The bunch count shown in that cycle belongs to the accept.

Top module: `trig_emu_top`

## Requirements
- R1: While reset is asserted and right after it, accept, trigType, orbitPulse, evtClrPulse, bunchCnt and evtCnt are zero. The register defaults are: threshold 0, orbit length 3564, veto windows 0, simple deadtime 0, bucket size 0, leak period 0, and trigger type 0.
- R2: bunchCnt counts 0 up to L-1 and then returns to 0, where L is the orbit length in register address 1, bits [11:0]. orbitPulse is high for exactly the cycles in which bunchCnt has just returned to 0, so consecutive pulses are L cycles apart.
- R3: A 32-bit maximal-length LFSR that never holds zero advances every clock. The LFSR offers a candidate when its value is less than or equal to the threshold in register address 0. A threshold of 0 never yields an accept, 32'hFFFFFFFF makes every cycle a candidate, and 32'h80000000 passes roughly half of all cycles.
- R4: Register address 2 sets two veto windows: P in bits [7:0] and Q in bits [23:16]. No accept occurs in a cycle whose bunchCnt is in L-P..L-1 or in 0..Q-1. Zero in a field turns that side of the window off.
- R5: Register address 3, bits [7:0], sets a simple deadtime D. After an accept, the next D cycles carry no accept. With every cycle a candidate, accepts repeat exactly every D+1 cycles.
- R6: Register address 4 sets the leaky bucket: size N in bits [3:0] and leak period R in bits [31:16]. Each accept adds one to the bucket. One unit leaks every R cycles. No accept is made while the bucket holds N or more. N=0 turns the bucket off and R=0 stops the leak.
- R7: If busyIn is high during a cycle, the following cycle carries no accept.
- R8: trigType equals the value in register address 5, bits [7:0], in every accept cycle, and is zero in every other cycle.
- R9: evtCnt increases by one for each accept. Writing 1 to bit 0 of register address 6 requests a clear. The clear takes effect in the next cycle in which orbitPulse is high, and evtClrPulse is high in that cycle only. After the clear, evtCnt is 0, or 1 if that same cycle carries an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bunch-crossing clock |
| rstN | input | 1 | active-low synchronous reset |
| regWe | input | 1 | register write strobe |
| regAddr | input | 3 | register address |
| regWdata | input | 32 | register write data |
| busyIn | input | 1 | external busy, blocks accepts |
| accept | output | 1 | level-1 accept pulse |
| trigType | output | 8 | trigger-type word, valid with accept |
| orbitPulse | output | 1 | bunch counter reset, one cycle per orbit |
| evtClrPulse | output | 1 | event counter reset pulse |
| bunchCnt | output | 12 | bunch-crossing counter |
| evtCnt | output | 24 | accepted-event counter |

## Verification
The hardest state to reach from the ports is a full leaky bucket whose leak phase is known exactly. Random accepts would leave both the fill and the leak timing uncertain. The bench therefore sets the threshold to all ones and turns off the other gates, so that every cycle is a candidate. It then enables the bucket with a single write while the leak counter is known to be idle. This fixes the fill to four back-to-back accepts and then one accept per leak period, cycle by cycle. A similar approach places the clear command mid-orbit with a post-boundary veto, so that the counter value at the next boundary is known exactly.

// File: rtl/trig_emu_pkg.sv
package trig_emu_pkg;

  typedef enum logic [2:0] {
    ADDR_THRESH = 3'd0,
    ADDR_ORBIT  = 3'd1,
    ADDR_VETO   = 3'd2,
    ADDR_DEAD   = 3'd3,
    ADDR_BUCKET = 3'd4,
    ADDR_TYPE   = 3'd5,
    ADDR_CMD    = 3'd6
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;
    logic clearEvt;
  } strobe_t;

  localparam int LFSR_W = 32;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 32'h8020_0003;

  function automatic logic [LFSR_W-1:0] lfsrStep(input logic [LFSR_W-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
  endfunction

endpackage

// File: rtl/trig_emu_regs.sv
module trig_emu_regs
  import trig_emu_pkg::*;
#(
  parameter int BC_W          = 12,
  parameter int VETO_W        = 8,
  parameter int DT_W          = 8,
  parameter int BKT_W         = 4,
  parameter int LEAK_W        = 16,
  parameter int TYPE_W        = 8,
  parameter int ORBIT_DEFAULT = 3564
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [LFSR_W-1:0] threshold,
  output logic [BC_W-1:0]   orbitLen,
  output logic [VETO_W-1:0] vetoPre,
  output logic [VETO_W-1:0] vetoPost,
  output logic [DT_W-1:0]   deadLen,
  output logic [BKT_W-1:0]  bucketSize,
  output logic [LEAK_W-1:0] leakPeriod,
  output logic [TYPE_W-1:0] typeVal,
  output logic              evtCmd
);

  localparam int HI_LSB = 16;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      threshold  <= '0;
      orbitLen   <= BC_W'(ORBIT_DEFAULT);
      vetoPre    <= '0;
      vetoPost   <= '0;
      deadLen    <= '0;
      bucketSize <= '0;
      leakPeriod <= '0;
      typeVal    <= '0;
    end else if (regWe) begin
      case (regSel_e'(regAddr))
        ADDR_THRESH: threshold <= regWdata[LFSR_W-1:0];
        ADDR_ORBIT:  orbitLen  <= regWdata[BC_W-1:0];
        ADDR_VETO: begin
          vetoPre  <= regWdata[VETO_W-1:0];
          vetoPost <= regWdata[HI_LSB +: VETO_W];
        end
        ADDR_DEAD:   deadLen <= regWdata[DT_W-1:0];
        ADDR_BUCKET: begin
          bucketSize <= regWdata[BKT_W-1:0];
          leakPeriod <= regWdata[HI_LSB +: LEAK_W];
        end
        ADDR_TYPE:   typeVal <= regWdata[TYPE_W-1:0];
        default: ;
      endcase
    end
  end

  assign evtCmd = regWe && (regSel_e'(regAddr) == ADDR_CMD) && regWdata[0];

endmodule

// File: rtl/trig_emu_ctrl.sv
module trig_emu_ctrl
  import trig_emu_pkg::*;
#(
  parameter int BC_W      = 12,
  parameter int VETO_W    = 8,
  parameter int DT_W      = 8,
  parameter int BKT_W     = 4,
  parameter int LEAK_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LFSR_W-1:0] threshold,
  input  logic [BC_W-1:0]   orbitLen,
  input  logic [VETO_W-1:0] vetoPre,
  input  logic [VETO_W-1:0] vetoPost,
  input  logic [DT_W-1:0]   deadLen,
  input  logic [BKT_W-1:0]  bucketSize,
  input  logic [LEAK_W-1:0] leakPeriod,
  input  logic              evtCmd,
  input  logic              busyIn,
  input  logic [BC_W-1:0]   bcntNext,
  input  logic              wrapNext,
  output strobe_t           strb,
  output logic [BKT_W-1:0]  bucketLevel,
  output logic [LFSR_W-1:0] lfsrState
);

  localparam int SUM_W = ((BC_W > VETO_W) ? BC_W : VETO_W) + 1;

  logic [DT_W-1:0]   deadCnt;
  logic [LEAK_W-1:0] leakCnt;
  logic [BKT_W-1:0]  levelNext;
  logic              clrPending;
  logic              candidate, preHit, postHit, vetoHit;
  logic              deadOk, bucketOk, leakTick, fire;
  logic [SUM_W-1:0]  preSum;

  // random candidate source
  always_ff @(posedge clk) begin
    if (!rstN) lfsrState <= LFSR_SEED;
    else       lfsrState <= lfsrStep(lfsrState);
  end
  assign candidate = (lfsrState <= threshold);

  // veto window judged on the bunch number the accept will carry
  assign preSum  = SUM_W'(bcntNext) + SUM_W'(vetoPre);
  assign preHit  = (vetoPre != '0) && (preSum >= SUM_W'(orbitLen));
  assign postHit = SUM_W'(bcntNext) < SUM_W'(vetoPost);
  assign vetoHit = preHit || postHit;

  assign deadOk   = (deadCnt == '0);
  assign bucketOk = (bucketSize == '0) || (bucketLevel < bucketSize);
  assign fire     = candidate && !vetoHit && !busyIn && deadOk && bucketOk;

  // simple deadtime
  always_ff @(posedge clk) begin
    if (!rstN)               deadCnt <= '0;
    else if (fire)           deadCnt <= deadLen;
    else if (deadCnt != '0)  deadCnt <= deadCnt - DT_W'(1);
  end

  // leaky bucket
  assign leakTick = (leakPeriod != '0) && (leakCnt >= leakPeriod - LEAK_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)                     leakCnt <= '0;
    else if (leakPeriod == '0)     leakCnt <= '0;
    else if (leakTick)             leakCnt <= '0;
    else                           leakCnt <= leakCnt + LEAK_W'(1);
  end

  always_comb begin
    levelNext = bucketLevel;
    if (bucketSize == '0) begin
      levelNext = '0;
    end else begin
      if (fire) levelNext = levelNext + BKT_W'(1);
      if (leakTick && (bucketLevel != '0)) levelNext = levelNext - BKT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) bucketLevel <= '0;
    else       bucketLevel <= levelNext;
  end

  // event clear deferred to the orbit boundary
  always_ff @(posedge clk) begin
    if (!rstN)                      clrPending <= 1'b0;
    else if (evtCmd)                clrPending <= 1'b1;
    else if (clrPending && wrapNext) clrPending <= 1'b0;
  end

  assign strb.fire     = fire;
  assign strb.clearEvt = clrPending && wrapNext;

endmodule

// File: rtl/trig_emu_dp.sv
module trig_emu_dp
  import trig_emu_pkg::*;
#(
  parameter int BC_W   = 12,
  parameter int EVT_W  = 24,
  parameter int TYPE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BC_W-1:0]   orbitLen,
  input  logic [TYPE_W-1:0] typeVal,
  input  strobe_t           strb,
  output logic [BC_W-1:0]   bcntNext,
  output logic              wrapNext,
  output logic              accept,
  output logic [TYPE_W-1:0] trigType,
  output logic              orbitPulse,
  output logic              evtClrPulse,
  output logic [BC_W-1:0]   bunchCnt,
  output logic [EVT_W-1:0]  evtCnt
);

  assign wrapNext = ({1'b0, bunchCnt} + (BC_W+1)'(1)) >= {1'b0, orbitLen};
  assign bcntNext = wrapNext ? '0 : bunchCnt + BC_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bunchCnt    <= '0;
      orbitPulse  <= 1'b0;
      accept      <= 1'b0;
      trigType    <= '0;
      evtClrPulse <= 1'b0;
      evtCnt      <= '0;
    end else begin
      bunchCnt    <= bcntNext;
      orbitPulse  <= wrapNext;
      accept      <= strb.fire;
      trigType    <= strb.fire ? typeVal : '0;
      evtClrPulse <= strb.clearEvt;
      if (strb.clearEvt) evtCnt <= EVT_W'(strb.fire);
      else               evtCnt <= evtCnt + EVT_W'(strb.fire);
    end
  end

endmodule

// File: rtl/trig_emu_top.sv
module trig_emu_top
  import trig_emu_pkg::*;
#(
  parameter int BC_W          = 12,
  parameter int EVT_W         = 24,
  parameter int TYPE_W        = 8,
  parameter int VETO_W        = 8,
  parameter int DT_W          = 8,
  parameter int BKT_W         = 4,
  parameter int LEAK_W        = 16,
  parameter int ORBIT_DEFAULT = 3564
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic              busyIn,
  output logic              accept,
  output logic [TYPE_W-1:0] trigType,
  output logic              orbitPulse,
  output logic              evtClrPulse,
  output logic [BC_W-1:0]   bunchCnt,
  output logic [EVT_W-1:0]  evtCnt
);

  logic [LFSR_W-1:0] threshold;
  logic [BC_W-1:0]   orbitLen;
  logic [VETO_W-1:0] vetoPre, vetoPost;
  logic [DT_W-1:0]   deadLen;
  logic [BKT_W-1:0]  bucketSize;
  logic [LEAK_W-1:0] leakPeriod;
  logic [TYPE_W-1:0] typeVal;
  logic              evtCmd;
  logic [BC_W-1:0]   bcntNext;
  logic              wrapNext;
  strobe_t           strb;
  logic [BKT_W-1:0]  bucketLevel;
  logic [LFSR_W-1:0] lfsrState;

  trig_emu_regs #(
    .BC_W(BC_W), .VETO_W(VETO_W), .DT_W(DT_W), .BKT_W(BKT_W),
    .LEAK_W(LEAK_W), .TYPE_W(TYPE_W), .ORBIT_DEFAULT(ORBIT_DEFAULT)
  ) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .threshold(threshold), .orbitLen(orbitLen), .vetoPre(vetoPre), .vetoPost(vetoPost),
    .deadLen(deadLen), .bucketSize(bucketSize), .leakPeriod(leakPeriod),
    .typeVal(typeVal), .evtCmd(evtCmd)
  );

  trig_emu_ctrl #(
    .BC_W(BC_W), .VETO_W(VETO_W), .DT_W(DT_W), .BKT_W(BKT_W), .LEAK_W(LEAK_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .threshold(threshold), .orbitLen(orbitLen),
    .vetoPre(vetoPre), .vetoPost(vetoPost), .deadLen(deadLen),
    .bucketSize(bucketSize), .leakPeriod(leakPeriod), .evtCmd(evtCmd),
    .busyIn(busyIn), .bcntNext(bcntNext), .wrapNext(wrapNext),
    .strb(strb), .bucketLevel(bucketLevel), .lfsrState(lfsrState)
  );

  trig_emu_dp #(
    .BC_W(BC_W), .EVT_W(EVT_W), .TYPE_W(TYPE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .orbitLen(orbitLen), .typeVal(typeVal), .strb(strb),
    .bcntNext(bcntNext), .wrapNext(wrapNext), .accept(accept), .trigType(trigType),
    .orbitPulse(orbitPulse), .evtClrPulse(evtClrPulse), .bunchCnt(bunchCnt),
    .evtCnt(evtCnt)
  );

endmodule

// File: rtl/trig_emu_chk.sv
module trig_emu_chk #(
  parameter int BC_W   = 12,
  parameter int EVT_W  = 24,
  parameter int TYPE_W = 8,
  parameter int VETO_W = 8,
  parameter int DT_W   = 8,
  parameter int BKT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic              busyIn,
  input logic              accept,
  input logic [TYPE_W-1:0] trigType,
  input logic              orbitPulse,
  input logic              evtClrPulse,
  input logic [BC_W-1:0]   bunchCnt,
  input logic [EVT_W-1:0]  evtCnt,
  input logic [BC_W-1:0]   orbitLen,
  input logic [VETO_W-1:0] vetoPre,
  input logic [VETO_W-1:0] vetoPost,
  input logic [DT_W-1:0]   deadLen,
  input logic [BKT_W-1:0]  bucketSize,
  input logic [BKT_W-1:0]  bucketLevel,
  input logic [31:0]       lfsrState
);

  localparam int CW = ((BC_W > VETO_W) ? BC_W : VETO_W) + 1;

  logic inWindow;
  assign inWindow = ((vetoPre != '0) && (CW'(bunchCnt) + CW'(vetoPre) >= CW'(orbitLen)))
                 || (CW'(bunchCnt) < CW'(vetoPost));

  assert_orbit_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    orbitPulse |-> (bunchCnt == '0));

  assert_lfsr_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != '0);

  assert_no_veto_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !$past(regWe)) |-> !inWindow);

  assert_dead_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !$past(regWe) && (deadLen != '0)) |=> !accept);

  assert_bucket_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((bucketSize != '0) && (bucketLevel >= bucketSize)) |=> !accept);

  assert_busy_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> !accept);

  assert_type_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !accept |-> (trigType == '0));

  assert_evt_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    !evtClrPulse |-> (evtCnt == $past(evtCnt) + EVT_W'(accept)));

  assert_evt_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    evtClrPulse |-> (orbitPulse && (evtCnt == EVT_W'(accept))));

endmodule

bind trig_emu_top trig_emu_chk #(
  .BC_W(BC_W), .EVT_W(EVT_W), .TYPE_W(TYPE_W),
  .VETO_W(VETO_W), .DT_W(DT_W), .BKT_W(BKT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .busyIn(busyIn), .accept(accept),
  .trigType(trigType), .orbitPulse(orbitPulse), .evtClrPulse(evtClrPulse),
  .bunchCnt(bunchCnt), .evtCnt(evtCnt), .orbitLen(orbitLen), .vetoPre(vetoPre),
  .vetoPost(vetoPost), .deadLen(deadLen), .bucketSize(bucketSize),
  .bucketLevel(bucketLevel), .lfsrState(lfsrState)
);

// File: tb/tb_trig_emu_top.sv
module tb_trig_emu_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        busyIn = 1'b0;
  logic        accept;
  logic [7:0]  trigType;
  logic        orbitPulse;
  logic        evtClrPulse;
  logic [11:0] bunchCnt;
  logic [23:0] evtCnt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  trig_emu_top dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .busyIn(busyIn), .accept(accept), .trigType(trigType), .orbitPulse(orbitPulse),
    .evtClrPulse(evtClrPulse), .bunchCnt(bunchCnt), .evtCnt(evtCnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // one clock edge, sample just after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    #1;
    regWe = 1'b0;
  endtask

  task automatic waitPulse(output int n);
    n = 0;
    do begin step(); n++; end while (!orbitPulse && n < 5000);
  endtask

  task automatic testReset();
    int n;
    int acc = 0;
    rstN = 1'b0;
    repeat (4) step();
    check(accept == 0 && trigType == 0 && orbitPulse == 0 && evtClrPulse == 0,
          "R1", "outputs in reset", accept, 0);
    check(bunchCnt == 0 && evtCnt == 0, "R1", "counters in reset", bunchCnt, 0);
    @(negedge clk); rstN = 1'b1;
    waitPulse(n);
    for (int i = 0; i < 3564; i++) begin
      step();
      acc += int'(accept);
      if (orbitPulse) begin
        check(i == 3563, "R1", "default orbit length", i + 1, 3564);
        break;
      end
    end
    check(acc == 0, "R3", "zero threshold gives no accepts", acc, 0);
  endtask

  task automatic testOrbit();
    int n;
    int maxB = 0;
    writeReg(3'd1, 32'd50);
    waitPulse(n);
    n = 0;
    do begin
      step(); n++;
      if (int'(bunchCnt) > maxB) maxB = int'(bunchCnt);
    end while (!orbitPulse && n < 200);
    check(n == 50, "R2", "orbit pulse spacing", n, 50);
    check(bunchCnt == 0, "R2", "bunch count at pulse", bunchCnt, 0);
    check(maxB == 49, "R2", "highest bunch count", maxB, 49);
  endtask

  task automatic testContinuous();
    int bad = 0;
    logic [23:0] prev;
    writeReg(3'd5, 32'hA5);
    writeReg(3'd0, 32'hFFFF_FFFF);
    step();
    prev = evtCnt;
    for (int i = 0; i < 20; i++) begin
      step();
      if (!(accept && trigType == 8'hA5 && (evtClrPulse || evtCnt == prev + 1))) bad++;
      prev = evtCnt;
    end
    check(bad == 0, "R3", "all-ones threshold fires every cycle", bad, 0);
    check(trigType == 8'hA5, "R8", "trigger type with accept", trigType, 8'hA5);
    check(bad == 0, "R9", "event count steps per accept", bad, 0);
  endtask

  task automatic testDeadtime();
    int n;
    writeReg(3'd3, 32'd3);
    repeat (6) step();
    n = 0;
    while (!accept && n < 20) begin step(); n++; end
    for (int k = 0; k < 5; k++) begin
      n = 0;
      do begin step(); n++; end while (!accept && n < 20);
      check(n == 4, "R5", "accept spacing with deadtime 3", n, 4);
    end
    writeReg(3'd3, 32'd0);
  endtask

  task automatic testVeto();
    int bad = 0;
    bit exp;
    writeReg(3'd2, 32'h0002_0003);
    step(); step();
    for (int i = 0; i < 120; i++) begin
      step();
      exp = (bunchCnt >= 2) && (bunchCnt <= 46);
      if (accept != exp) begin
        bad++;
        check(1'b0, "R4", "accept vs veto window", accept, exp);
      end
    end
    check(bad == 0, "R4", "veto window over two orbits", bad, 0);
    writeReg(3'd2, 32'h0);
  endtask

  task automatic testBusy();
    step(); step();
    @(negedge clk); busyIn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step();
      check(accept == 0, "R7", "busy blocks accept", accept, 0);
      check(trigType == 0, "R8", "type zero without accept", trigType, 0);
    end
    @(negedge clk); busyIn = 1'b0;
    step();
    check(accept == 1, "R7", "accept resumes after busy", accept, 1);
  endtask

  task automatic testBucket();
    int cnt = 0;
    bit exp;
    int bad = 0;
    writeReg(3'd4, 32'h0014_0004);
    check(accept == 1, "R6", "accept at bucket enable edge", accept, 1);
    for (int k = 1; k <= 21; k++) begin
      step();
      exp = (k <= 4) || (k == 21);
      if (accept != exp) begin
        bad++;
        check(1'b0, "R6", "bucket fill and leak pattern", accept, exp);
      end
    end
    check(bad == 0, "R6", "burst of four then leak", bad, 0);
    for (int k = 22; k <= 221; k++) begin
      step();
      cnt += int'(accept);
    end
    check(cnt == 10, "R6", "sustained rate one per leak period", cnt, 10);
    writeReg(3'd4, 32'h0);
  endtask

  task automatic testEvtClear();
    int n;
    logic [23:0] v;
    bit early = 1'b0;
    writeReg(3'd2, 32'h0005_0000);
    waitPulse(n);
    repeat (10) step();
    v = evtCnt;
    writeReg(3'd6, 32'h1);
    n = 0;
    do begin
      step(); n++;
      if (!orbitPulse && (evtClrPulse || evtCnt < v)) early = 1'b1;
    end while (!orbitPulse && n < 100);
    check(!early, "R9", "no clear before boundary", early, 0);
    check(evtClrPulse == 1, "R9", "clear pulse at boundary", evtClrPulse, 1);
    check(evtCnt == 0, "R9", "count cleared at boundary", evtCnt, 0);
    waitPulse(n);
    check(evtClrPulse == 0, "R9", "single clear pulse", evtClrPulse, 0);
    check(evtCnt == 45, "R9", "accepts counted in one orbit", evtCnt, 45);
    writeReg(3'd2, 32'h0);
    waitPulse(n);
    repeat (5) step();
    writeReg(3'd6, 32'h1);
    waitPulse(n);
    check(evtClrPulse == 1 && accept == 1, "R9", "clear with accept", accept, 1);
    check(evtCnt == 1, "R9", "count after clear with accept", evtCnt, 1);
  endtask

  task automatic testRate();
    int cnt = 0;
    writeReg(3'd0, 32'h8000_0000);
    for (int i = 0; i < 4000; i++) begin
      step();
      cnt += int'(accept);
    end
    check(cnt >= 1400 && cnt <= 2600, "R3", "half threshold rate", cnt, 2000);
    writeReg(3'd0, 32'h0);
    step();
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      step();
      cnt += int'(accept);
    end
    check(cnt == 0, "R3", "zero threshold stops accepts", cnt, 0);
  endtask

  task automatic testTypeChange();
    writeReg(3'd5, 32'h3C);
    writeReg(3'd0, 32'hFFFF_FFFF);
    step(); step();
    check(accept == 1, "R8", "accept present", accept, 1);
    check(trigType == 8'h3C, "R8", "new trigger type", trigType, 8'h3C);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testOrbit();
    testContinuous();
    testDeadtime();
    testVeto();
    testBusy();
    testBucket();
    testEvtClear();
    testRate();
    testTypeChange();
    finishRun();
  end

endmodule